// File: doc/BRIEF.md
# UART FIFO DMA Ready Signalling

This block holds the character queues of one UART channel, a transmit FIFO and a receive FIFO of 16 characters each. It drives the two active-low ready pins that pace an external DMA controller. The serial side pops transmit characters and pushes received ones. The host side pushes transmit characters and pops received ones. The block reports both fill counts.

The ready pins have two behaviours. In single-character mode, each pin tracks whether one character can be moved. In block mode, the transmit pin stays asserted while any transmit location is free. In the same mode, the receive pin asserts once the receive count reaches a selectable trigger level, or once the serial side reports a receive time-out while data is held. Block mode is active only when the FIFO enable and the DMA mode select are both set. With the FIFO enable clear, each direction holds a single character, like a plain holding register.

Top module: `uart_dma_ready`

## Requirements
- R1: After reset, both counts are 0, tx_rdy_no is 0 and rx_rdy_no is 1.
- R2: Each FIFO returns characters in push order. It holds at most DEPTH (16) characters, and a push while full is ignored.
- R3: A pop while empty is ignored. A push and a pop in the same cycle on a FIFO that is neither empty nor full leave its count unchanged.
- R4: With fifo_en_i = 0, each FIFO holds at most one character. Any change of fifo_en_i empties both FIFOs at the next clock edge.
- R5: Outside block mode, rx_rdy_no is 0 while the receive count is at least 1, and 1 when it is 0.
- R6: Outside block mode, tx_rdy_no is 0 while the transmit count is 0, and 1 once a character is held.
- R7: In block mode, tx_rdy_no is 1 only when the transmit count equals DEPTH, and 0 otherwise.
- R8: In block mode, rx_rdy_no goes to 0 once the receive count reaches the trigger level. rx_trig_sel_i encodes the level as 2'b00 = 1, 2'b01 = 4, 2'b10 = 8 and 2'b11 = 14 characters.
- R9: In block mode, rx_timeout_i = 1 drives rx_rdy_no to 0 in the same cycle while the receive count is non-zero. It has no effect when the receive FIFO is empty.
- R10: In block mode, rx_rdy_no returns to 1 once reads empty the receive FIFO.
- R11: Block mode needs fifo_en_i = 1 and dma_mode_i = 1. With dma_mode_i = 1 and fifo_en_i = 0, the single-character behaviour of R5 and R6 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO enable; 0 gives one-character holding |
| dma_mode_i | input | 1 | Selects block-mode ready signalling |
| rx_trig_sel_i | input | 2 | Receive trigger level select |
| rx_timeout_i | input | 1 | Receive time-out flag from the serial side |
| tx_push_i | input | 1 | Host writes a transmit character |
| tx_data_i | input | 8 | Transmit character in |
| tx_pop_i | input | 1 | Serial side takes the transmit head |
| tx_data_o | output | 8 | Transmit FIFO head |
| rx_push_i | input | 1 | Serial side delivers a received character |
| rx_data_i | input | 8 | Received character in |
| rx_pop_i | input | 1 | Host reads the receive head |
| rx_data_o | output | 8 | Receive FIFO head |
| tx_rdy_no | output | 1 | Transmit ready to DMA, active low |
| rx_rdy_no | output | 1 | Receive ready to DMA, active low |
| tx_count_o | output | 5 | Transmit fill count |
| rx_count_o | output | 5 | Receive fill count |

## Verification
A push and a pop on the same FIFO can fall in the same cycle. That cycle moves both pointers while the count must hold. The bench provokes this by asserting both strobes together on a part-filled transmit FIFO. It then judges the unchanged count and the surviving head character. A receive time-out can also arrive in a cycle where the count is below the trigger. The bench raises the flag with the count under the level, once with data held and once with the FIFO empty, and checks the receive pin without an intervening clock edge.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (trig_sel_e'(sel))
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             one_deep_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic full, empty, push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = one_deep_i ? (count_q != '0) : (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = push_i && !full && !flush_i;
  assign pop_ok  = pop_i && !empty && !flush_i;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/uart_rdy_logic.sv
module uart_rdy_logic
  import uart_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             block_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             rx_timeout_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_count_i,
  output logic             tx_rdy_no,
  output logic             rx_rdy_no
);
  logic [CNT_W-1:0] trig;
  logic rx_any, rx_low, tx_low;

  assign trig   = CNT_W'(trig_level(trig_sel_i));
  assign rx_any = (rx_count_i != '0);

  always_comb begin
    if (block_i) begin
      rx_low = (rx_count_i >= trig) || (rx_timeout_i && rx_any);
      tx_low = (tx_count_i != CNT_W'(DEPTH));
    end else begin
      rx_low = rx_any;
      tx_low = (tx_count_i == '0);
    end
  end

  assign tx_rdy_no = !tx_low;
  assign rx_rdy_no = !rx_low;
endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             dma_mode_i,
  input  logic [1:0]       rx_trig_sel_i,
  input  logic             rx_timeout_i,
  input  logic             tx_push_i,
  input  logic [WIDTH-1:0] tx_data_i,
  input  logic             tx_pop_i,
  output logic [WIDTH-1:0] tx_data_o,
  input  logic             rx_push_i,
  input  logic [WIDTH-1:0] rx_data_i,
  input  logic             rx_pop_i,
  output logic [WIDTH-1:0] rx_data_o,
  output logic             tx_rdy_no,
  output logic             rx_rdy_no,
  output logic [CNT_W-1:0] tx_count_o,
  output logic [CNT_W-1:0] rx_count_o
);
  logic en_q, flush, block;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= fifo_en_i;
  end

  assign flush = (en_q != fifo_en_i);
  assign block = fifo_en_i && dma_mode_i;

  uart_sync_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .one_deep_i(!fifo_en_i),
    .push_i(tx_push_i), .data_i(tx_data_i), .pop_i(tx_pop_i),
    .data_o(tx_data_o), .count_o(tx_count_o)
  );

  uart_sync_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .one_deep_i(!fifo_en_i),
    .push_i(rx_push_i), .data_i(rx_data_i), .pop_i(rx_pop_i),
    .data_o(rx_data_o), .count_o(rx_count_o)
  );

  uart_rdy_logic #(.DEPTH(DEPTH)) u_rdy (
    .block_i(block), .trig_sel_i(rx_trig_sel_i), .rx_timeout_i,
    .tx_count_i(tx_count_o), .rx_count_i(rx_count_o),
    .tx_rdy_no, .rx_rdy_no
  );
endmodule

// File: rtl/uart_dma_ready_chk.sv
module uart_dma_ready_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             dma_mode_i,
  input logic             tx_push_i,
  input logic             tx_pop_i,
  input logic             rx_push_i,
  input logic             rx_pop_i,
  input logic             tx_rdy_no,
  input logic             rx_rdy_no,
  input logic [CNT_W-1:0] tx_count_o,
  input logic [CNT_W-1:0] rx_count_o
);
  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_count_o <= CNT_W'(DEPTH) && rx_count_o <= CNT_W'(DEPTH));

  a_r2_full_push_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && $stable(fifo_en_i) && tx_count_o == CNT_W'(DEPTH) && tx_push_i && !tx_pop_i
    |=> tx_count_o == CNT_W'(DEPTH));

  a_r3_empty_pop_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count_o == '0 && rx_pop_i && !rx_push_i |=> rx_count_o == '0);

  a_r3_push_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && $stable(fifo_en_i) && tx_push_i && tx_pop_i &&
    tx_count_o != '0 && tx_count_o != CNT_W'(DEPTH) |=> $stable(tx_count_o));

  a_r6_tx_empty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_en_i && dma_mode_i) && tx_count_o == '0 |-> !tx_rdy_no);

  a_r7_tx_block_free_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && dma_mode_i && tx_count_o != CNT_W'(DEPTH) |-> !tx_rdy_no);

  a_r10_rx_empty_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count_o == '0 |-> rx_rdy_no);
endmodule

bind uart_dma_ready uart_dma_ready_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i), .dma_mode_i(dma_mode_i),
  .tx_push_i(tx_push_i), .tx_pop_i(tx_pop_i), .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
  .tx_rdy_no(tx_rdy_no), .rx_rdy_no(rx_rdy_no),
  .tx_count_o(tx_count_o), .rx_count_o(rx_count_o)
);

// File: tb/uart_dma_ready_bench.sv
module uart_dma_ready_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic fifo_en = 1'b1, dma_mode = 1'b0, rx_timeout = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_din = '0, rx_din = '0, tx_dout, rx_dout;
  logic tx_rdy_n, rx_rdy_n;
  logic [4:0] tx_cnt, rx_cnt;
  int checks = 0, errors = 0;

  // {trig_sel, pushes, expected rx_rdy_no}
  localparam logic [7:0] TRIG_VEC [9] = '{
    {2'd0, 5'd0, 1'b1}, {2'd0, 5'd1, 1'b0},
    {2'd1, 5'd3, 1'b1}, {2'd1, 5'd4, 1'b0},
    {2'd2, 5'd7, 1'b1}, {2'd2, 5'd8, 1'b0},
    {2'd3, 5'd13, 1'b1}, {2'd3, 5'd14, 1'b0},
    {2'd3, 5'd16, 1'b0}
  };

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_dma_ready u_uart_dma_ready (
    .clk_i(clk), .rst_ni, .fifo_en_i(fifo_en), .dma_mode_i(dma_mode),
    .rx_trig_sel_i(trig_sel), .rx_timeout_i(rx_timeout),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_dout),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop), .rx_data_o(rx_dout),
    .tx_rdy_no(tx_rdy_n), .rx_rdy_no(rx_rdy_n),
    .tx_count_o(tx_cnt), .rx_count_o(rx_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic tpu, input logic tpo, input logic rpu, input logic rpo);
    tx_push = tpu; tx_pop = tpo; rx_push = rpu; rx_pop = rpo;
    @(posedge clk); #1;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
  endtask

  task automatic drain_rx();
    while (rx_cnt != 0) step(0, 0, 0, 1);
  endtask

  task automatic drain_tx();
    while (tx_cnt != 0) step(0, 1, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk("R1 tx_count", tx_cnt, 0);
    chk("R1 rx_count", rx_cnt, 0);
    chk("R1 tx_rdy_no", tx_rdy_n, 0);
    chk("R1 rx_rdy_no", rx_rdy_n, 1);
    step(0, 0, 0, 0);

    // R5 / R6 single-character mode
    rx_din = 8'h5a; step(0, 0, 1, 0);
    chk("R5 rx low with data", rx_rdy_n, 0);
    tx_din = 8'h11; step(1, 0, 0, 0);
    chk("R6 tx high when loaded", tx_rdy_n, 1);
    chk("R5 rx head", rx_dout, 8'h5a);
    step(0, 1, 0, 1);
    chk("R5 rx high when empty", rx_rdy_n, 1);
    chk("R6 tx low when empty", tx_rdy_n, 0);

    // R2 order, depth, overflow
    for (int i = 0; i < DEPTH; i++) begin tx_din = 8'(i * 17 + 3); step(1, 0, 0, 0); end
    chk("R2 tx full count", tx_cnt, DEPTH);
    tx_din = 8'hee; step(1, 0, 0, 0);
    chk("R2 push on full ignored", tx_cnt, DEPTH);
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        if (tx_dout != 8'(i * 17 + 3)) bad++;
        step(0, 1, 0, 0);
      end
      chk("R2 order mismatches", bad, 0);
    end
    chk("R2 drained", tx_cnt, 0);

    // R3 empty pop, simultaneous push/pop
    step(0, 0, 0, 1);
    chk("R3 pop on empty ignored", rx_cnt, 0);
    tx_din = 8'ha1; step(1, 0, 0, 0);
    tx_din = 8'ha2; step(1, 0, 0, 0);
    tx_din = 8'ha3; step(1, 1, 0, 0);
    chk("R3 push+pop count held", tx_cnt, 2);
    chk("R3 push+pop head", tx_dout, 8'ha2);
    drain_tx();

    // R7 block tx
    dma_mode = 1'b1;
    for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, 0);
    chk("R7 tx low at 15", tx_rdy_n, 0);
    step(1, 0, 0, 0);
    chk("R7 tx high when full", tx_rdy_n, 1);
    step(0, 1, 0, 0);
    chk("R7 tx low after one free", tx_rdy_n, 0);
    drain_tx();

    // R8 trigger levels
    foreach (TRIG_VEC[k]) begin
      drain_rx();
      trig_sel = TRIG_VEC[k][7:6];
      for (int n = 0; n < int'(TRIG_VEC[k][5:1]); n++) step(0, 0, 1, 0);
      chk($sformatf("R8 trig sel %0d count %0d", TRIG_VEC[k][7:6], TRIG_VEC[k][5:1]),
          rx_rdy_n, TRIG_VEC[k][0]);
    end
    drain_rx();

    // R9 time-out
    trig_sel = 2'b11;
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    chk("R9 below trigger high", rx_rdy_n, 1);
    rx_timeout = 1'b1; #1;
    chk("R9 time-out with data low", rx_rdy_n, 0);
    drain_rx();
    chk("R9 time-out while empty high", rx_rdy_n, 1);
    rx_timeout = 1'b0;

    // R10 release after emptying
    trig_sel = 2'b00;
    repeat (3) step(0, 0, 1, 0);
    step(0, 0, 0, 1); step(0, 0, 0, 1);
    chk("R10 still low with one left", rx_rdy_n, 0);
    step(0, 0, 0, 1);
    chk("R10 high once emptied", rx_rdy_n, 1);

    // R11 / R4 FIFO disabled with DMA select set
    repeat (3) step(0, 0, 1, 0);
    fifo_en = 1'b0; step(0, 0, 0, 0);
    chk("R4 flush on disable", rx_cnt, 0);
    trig_sel = 2'b11;
    step(1, 0, 1, 0);
    chk("R11 tx single-char high", tx_rdy_n, 1);
    chk("R11 rx single-char low", rx_rdy_n, 0);
    step(1, 0, 1, 0);
    chk("R4 one-deep tx", tx_cnt, 1);
    chk("R4 one-deep rx", rx_cnt, 1);
    fifo_en = 1'b1; step(0, 0, 0, 0);
    chk("R4 flush on enable", tx_cnt, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule